// File: doc/BRIEF.md
# DDR Controller Configuration Register Stub

This block stands in for the configuration and status registers of a DDR memory controller. It lets boot firmware run its initialization, training and impedance-calibration sequences without a real controller, PHY or memory behind it. Each request that firmware starts reports completion at once, so polling loops finish on their first read.

The block sits on a simple 32-bit register bus. The bus signals are a select, a write enable, a word address, write data, read data and a ready strobe. Every access takes one cycle. Read data and ready are registered and appear in the cycle after the select. Three registers exist, at word indices 0, 42 and 44, which are byte offsets 0x000, 0x0A8 and 0x0B0. The first is a main control register. The second is an impedance-calibration control register. The third is a calibration status register. Every other word in the window reads as zero, and writes to those words are dropped.

Reset is synchronous and active low. The word-address width is a parameter and must be at least 6 bits. The default of 10 bits covers a 4 KiB window.

Top module: `mcfg_stub`

## Requirements
- R1: After reset, word 0 reads 0x80020000, word 42 reads 0x07B00000 and word 44 reads 0x80000000.
- R2: A write to word 0 stores bits 29..0 as written and stores bits 31 (init request) and 30 (training request) as 0, whatever value was written to them.
- R3: A write to word 42 stores the written value in that register and sets bit 31 (calibration done) of word 44. Bits 30..0 of word 44 keep their values.
- R4: A write to word 44 replaces all 32 bits of that register with the written value, including clearing bit 31.
- R5: A read of any word other than 0, 42 and 44 returns 0. This includes words 0xB9 (byte 0x2E4) through the top of the window.
- R6: A write to any word other than 0, 42 and 44 leaves all three registers unchanged.
- R7: bus_ready is 1 in exactly the cycles that follow a cycle with bus_sel high. bus_rdata in such a cycle holds the addressed register's value from before that access if the access was a read. In every other cycle bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Access completed in the previous cycle |

## Verification
Two functions meet in time here. A write to the calibration control register sets the done flag in the status register. A read of the status register in the very next cycle must already see that flag. The bench provokes this by holding select high across a calibration write and an immediate status read, and across a status write followed by a calibration write. A per-cycle behavioural model predicts ready and read data on every clock, so a stale or lost done bit shows up in the exact cycle it occurs.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
    localparam int DATA_W   = 32;
    localparam int NREG     = 3;
    localparam int IDX_CTRL = 0;
    localparam int IDX_CAL  = 1;
    localparam int IDX_STAT = 2;

    // Bit positions that the firmware sequence depends on
    localparam int BIT_INIT_REQ  = 31;
    localparam int BIT_TRAIN_REQ = 30;
    localparam int BIT_CAL_DONE  = 31;

    typedef logic [DATA_W-1:0] word_t;
    typedef word_t [NREG-1:0]  regvec_t;

    // Word index of each implemented register
    function automatic int unsigned reg_word(int idx);
        case (idx)
            IDX_CTRL: return 32'd0;
            IDX_CAL:  return 32'd42;
            default:  return 32'd44;
        endcase
    endfunction

    // Value each implemented register takes at reset
    function automatic word_t reg_reset(int idx);
        case (idx)
            IDX_CTRL: return 32'h8002_0000;
            IDX_CAL:  return 32'h07B0_0000;
            default:  return 32'h8000_0000;
        endcase
    endfunction
endpackage

// File: rtl/mcfg_decode.sv
module mcfg_decode
    import mcfg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (addr == ADDR_W'(reg_word(i)));
    end
endmodule

// File: rtl/mcfg_regs.sv
module mcfg_regs
    import mcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NREG-1:0] hit,
    input  word_t           wdata,
    output regvec_t         regs
);
    typedef struct packed {
        word_t ctrl;
        word_t cal;
        word_t stat;
    } state_t;

    localparam word_t REQ_MASK = word_t'((64'd1 << BIT_INIT_REQ) | (64'd1 << BIT_TRAIN_REQ));

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (hit[IDX_CTRL]) begin
                st_d.ctrl = wdata & ~REQ_MASK;
            end
            if (hit[IDX_CAL]) begin
                st_d.cal = wdata;
                st_d.stat[BIT_CAL_DONE] = 1'b1;
            end
            // a direct status write wins over the done side effect
            if (hit[IDX_STAT]) begin
                st_d.stat = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl <= reg_reset(IDX_CTRL);
            st_q.cal  <= reg_reset(IDX_CAL);
            st_q.stat <= reg_reset(IDX_STAT);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        regs           = '0;
        regs[IDX_CTRL] = st_q.ctrl;
        regs[IDX_CAL]  = st_q.cal;
        regs[IDX_STAT] = st_q.stat;
    end
endmodule

// File: rtl/mcfg_bus.sv
module mcfg_bus
    import mcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            we,
    input  logic [NREG-1:0] hit,
    input  regvec_t         regs,
    output word_t           rdata,
    output logic            ready
);
    typedef struct packed {
        word_t rdata;
        logic  ready;
    } resp_t;

    resp_t rs_d, rs_q;
    word_t mux_val;

    always_comb begin
        mux_val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                mux_val = mux_val | regs[i];
            end
        end
    end

    always_comb begin
        rs_d.ready = sel;
        rs_d.rdata = (sel && !we) ? mux_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rdata = rs_q.rdata;
    assign ready = rs_q.ready;
endmodule

// File: rtl/mcfg_stub.sv
module mcfg_stub
    import mcfg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready
);
    logic [NREG-1:0] hit;
    regvec_t         regs;
    word_t           ctrl_q, cal_q, stat_q;

    mcfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    mcfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_sel && bus_we),
        .hit   (hit),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    mcfg_bus u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .we    (bus_we),
        .hit   (hit),
        .regs  (regs),
        .rdata (bus_rdata),
        .ready (bus_ready)
    );

    assign ctrl_q = regs[IDX_CTRL];
    assign cal_q  = regs[IDX_CAL];
    assign stat_q = regs[IDX_STAT];
endmodule

// File: rtl/mcfg_stub_chk.sv
module mcfg_stub_chk
    import mcfg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_ready,
    input logic [31:0]       ctrl_q,
    input logic [31:0]       cal_q,
    input logic [31:0]       stat_q
);
    logic at_ctrl, at_cal, at_stat, at_none;
    assign at_ctrl = (bus_addr == ADDR_W'(0));
    assign at_cal  = (bus_addr == ADDR_W'(42));
    assign at_stat = (bus_addr == ADDR_W'(44));
    assign at_none = !(at_ctrl || at_cal || at_stat);

    // R7: ready follows select by one cycle
    p_ready_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);
    p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (!bus_ready && bus_rdata == 32'h0));

    // R2: request bits never survive a control write
    p_ctrl_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && at_ctrl) |=>
            (ctrl_q[31:30] == 2'b00 && ctrl_q[29:0] == $past(bus_wdata[29:0])));

    // R3: calibration write sets done and keeps the rest of status
    p_cal_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && at_cal) |=>
            (stat_q[31] && stat_q[30:0] == $past(stat_q[30:0]) && cal_q == $past(bus_wdata)));

    // R4: status register takes a direct write
    p_stat_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && at_stat) |=> (stat_q == $past(bus_wdata)));

    // R5: unmapped read returns zero
    p_unmapped_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && at_none) |=> (bus_rdata == 32'h0));

    // R6: unmapped write leaves every register alone
    p_unmapped_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && at_none) |=>
            ($stable(ctrl_q) && $stable(cal_q) && $stable(stat_q)));
endmodule

bind mcfg_stub mcfg_stub_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .ctrl_q    (ctrl_q),
    .cal_q     (cal_q),
    .stat_q    (stat_q)
);

// File: tb/sim_mcfg_stub.sv
`timescale 1ns/1ps
module sim_mcfg_stub;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          ready;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural model
    logic [31:0] m_ctrl, m_cal, m_stat, exp_rdata;
    logic        exp_ready;
    bit          started = 0;

    always #5 clk = ~clk;

    mcfg_stub #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 32'h8002_0000;
            m_cal  = 32'h07B0_0000;
            m_stat = 32'h8000_0000;
            exp_ready = 1'b0;
            exp_rdata = 32'h0;
        end else begin
            exp_ready = sel;
            exp_rdata = 32'h0;
            if (sel && !we) begin
                if (addr == 0)       exp_rdata = m_ctrl;
                else if (addr == 42) exp_rdata = m_cal;
                else if (addr == 44) exp_rdata = m_stat;
            end
            if (sel && we) begin
                if (addr == 0) m_ctrl = wdata & 32'h3FFF_FFFF;
                else if (addr == 42) begin
                    m_cal = wdata;
                    m_stat[31] = 1'b1;
                end else if (addr == 44) m_stat = wdata;
            end
        end
        started = 1;
    end

    // per-cycle comparison against the model (R7 plus the active requirement)
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (ready !== exp_ready || rdata !== exp_rdata) begin
                errors++;
                $display("FAIL %s/R7: ready=%b rdata=%h expected ready=%b rdata=%h",
                         cur_req, ready, rdata, exp_ready, exp_rdata);
            end
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a; wdata = 32'h0;
        @(negedge clk);
        checks++;
        if (rdata !== exp || ready !== 1'b1) begin
            errors++;
            $display("FAIL %s: word %0d read %h ready %b, expected %h ready 1",
                     req, a, rdata, ready, exp);
        end
        sel = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: idle cycle gives ready low and zero data
        @(negedge clk);
        checks++;
        if (ready !== 1'b0 || rdata !== 32'h0) begin
            errors++;
            $display("FAIL R7: idle ready=%b rdata=%h, expected 0 and 0", ready, rdata);
        end

        cur_req = "R1";
        rd_chk(0,  32'h8002_0000, "R1");
        rd_chk(42, 32'h07B0_0000, "R1");
        rd_chk(44, 32'h8000_0000, "R1");

        cur_req = "R5";
        rd_chk(1,    32'h0, "R5");
        rd_chk(43,   32'h0, "R5");
        rd_chk(45,   32'h0, "R5");
        rd_chk(10'hB9, 32'h0, "R5");
        rd_chk(10'h3FF, 32'h0, "R5");

        cur_req = "R2";
        bus_wr(0, 32'hFFFF_FFFF);
        rd_chk(0, 32'h3FFF_FFFF, "R2");
        bus_wr(0, 32'hC000_0000);
        rd_chk(0, 32'h0000_0000, "R2");
        bus_wr(0, 32'h4000_1234);
        rd_chk(0, 32'h0000_1234, "R2");

        cur_req = "R4";
        bus_wr(44, 32'h0000_00A5);
        rd_chk(44, 32'h0000_00A5, "R4");

        cur_req = "R3";
        bus_wr(42, 32'h1234_5678);
        rd_chk(44, 32'h8000_00A5, "R3");
        rd_chk(42, 32'h1234_5678, "R3");
        // back-to-back: status write, calibration write, status read
        bus_wr(44, 32'h0000_0F0F);
        bus_wr(42, 32'hCAFE_0001);
        rd_chk(44, 32'h8000_0F0F, "R3");
        // clearing done directly, then re-setting it
        cur_req = "R4";
        bus_wr(44, 32'h7FFF_FFFF);
        rd_chk(44, 32'h7FFF_FFFF, "R4");
        cur_req = "R3";
        bus_wr(42, 32'h0);
        rd_chk(44, 32'hFFFF_FFFF, "R3");

        cur_req = "R6";
        bus_wr(1,      32'hFFFF_FFFF);
        bus_wr(43,     32'hFFFF_FFFF);
        bus_wr(10'hB9, 32'h0);
        bus_wr(10'h3FF, 32'h5555_5555);
        idle();
        rd_chk(0,  32'h0000_1234, "R6");
        rd_chk(42, 32'h0000_0000, "R6");
        rd_chk(44, 32'hFFFF_FFFF, "R6");
        rd_chk(1,  32'h0, "R6");

        // R1 again after a second reset
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(0,  32'h8002_0000, "R1");
        rd_chk(42, 32'h07B0_0000, "R1");
        rd_chk(44, 32'h8000_0000, "R1");

        idle();
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule